// File: doc/BRIEF.md
# Programmable-Timing Asynchronous Memory Bus Controller

This block runs one read or one write at a time on an external asynchronous memory bus. The bus has up to six active-low chip selects, a 9-bit word address, a 16-bit data path and active-low output-enable and write-enable strobes. A host hands over a request through a valid/ready handshake: a chip-select index, an address, a direction flag and write data. The block answers with a one-cycle done pulse, and for a read, the captured data word.

Every chip select has its own timing fields, supplied as static configuration vectors. These set the read and write strobe widths, the write hold after the write strobe, the bus recovery gap, and the extra latency on the first access to a 16-word page. The controller records the previous access and uses it to decide whether a recovery gap or a page latency goes in front of the new strobe.

The state machine has six states. ST_IDLE waits for a request. ST_RECOV keeps the bus fully released. ST_LAT asserts the chip select with no strobe. ST_READ drives output-enable low. ST_WRITE drives write-enable low and the data. ST_HOLD keeps the chip select and data after write-enable rises. The transitions are:
- IDLE to RECOV when recovery is needed.
- IDLE to LAT when a new page has non-zero latency.
- IDLE to READ or WRITE in all other cases.
- RECOV to LAT, READ or WRITE when its count ends.
- LAT to READ or WRITE when its count ends.
- READ to IDLE when its count ends.
- WRITE to HOLD when its count ends.
- HOLD to IDLE when its count ends.

Top module: `async_mem_ctrl`

## Requirements
- R1: After reset every chip select, output-enable and write-enable is high, the data driver is off, req_ready is 1 and rsp_done is 0.
- R2: A read holds its chip select low with ext_oe_n low for read-wait + 1 cycles. The word on ext_dq_in in the last of those cycles is returned on rsp_rdata together with rsp_done.
- R3: A write drives ext_we_n low for write-wait + 1 cycles. While ext_we_n is low, ext_dq_oe is 1, ext_dq_out carries the write data and ext_addr carries the address.
- R4: After ext_we_n rises, the chip select stays low and the data stays driven for write-hold + 1 cycles. rsp_done follows these cycles.
- R5: Before an access, the bus stays fully released for max(R,1) cycles, where R is the recovery field of the previous access's chip select. This happens in two cases: the previous access was a read to a different chip select, or the previous access was a read and the new access is a write to the same chip select.
- R6: No recovery cycles go in after a write, or between two reads on the same chip select.
- R7: The first access after reset, or an access whose chip select or address bits [8:4] differ from the previous access, gets L cycles with only its chip select low before the strobe. L is the read or write latency field of that chip select. Other accesses get none.
- R8: req_ready is 1 only while idle. rsp_done is a single-cycle pulse. The access time from the accepting edge to the done pulse is recovery + latency + wait + 1, plus hold + 1 for a write.
- R9: Timing comes from the addressed chip select. Lane i of each configuration vector sits at bits [4i+3:4i] for the 4-bit fields and [8i+7:8i] for the 8-bit latency fields. ext_cs_n bit i belongs to chip select i.
- R10: ext_oe_n and ext_we_n are never low together. At most one chip select is low. ext_dq_oe is never 1 while ext_oe_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, takes a request |
| req_cs | input | 3 | Chip-select index |
| req_addr | input | 9 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| cfg_rd_wait | input | 24 | Read wait field per chip select |
| cfg_wr_wait | input | 24 | Write wait field per chip select |
| cfg_wr_hold | input | 24 | Write hold field per chip select |
| cfg_recov | input | 24 | Recovery field per chip select |
| cfg_rd_lat | input | 48 | Read page latency per chip select |
| cfg_wr_lat | input | 48 | Write page latency per chip select |
| ext_cs_n | output | 6 | Active-low chip selects |
| ext_addr | output | 9 | Bus address |
| ext_oe_n | output | 1 | Active-low output enable |
| ext_we_n | output | 1 | Active-low write enable |
| ext_dq_out | output | 16 | Data driven to the bus |
| ext_dq_oe | output | 1 | Data driver enable |
| ext_dq_in | input | 16 | Data read from the bus |

## Verification
A wrong count or a wrong state shows up as a strobe or chip-select window that is too long or too short. This is visible within the same access, at the latest on its done pulse. Stale history state shows up on the next access as a recovery gap or page latency that should not be there, or that is missing. A mis-sequenced state (strobes overlapping, data driven into a read, two selects low) is flagged in the cycle where it occurs.

// File: rtl/async_mem_pkg.sv
package async_mem_pkg;
    localparam int WAIT_W = 4;
    localparam int LAT_W  = 8;
    localparam int CNT_W  = (LAT_W > WAIT_W) ? LAT_W : WAIT_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECOV,
        ST_LAT,
        ST_READ,
        ST_WRITE,
        ST_HOLD
    } state_t;

    typedef struct packed {
        logic [WAIT_W-1:0] rd_wait;
        logic [WAIT_W-1:0] wr_wait;
        logic [WAIT_W-1:0] wr_hold;
        logic [WAIT_W-1:0] recov;
        logic [LAT_W-1:0]  rd_lat;
        logic [LAT_W-1:0]  wr_lat;
    } timing_t;
endpackage

// File: rtl/async_mem_cfgmux.sv
module async_mem_cfgmux
    import async_mem_pkg::*;
#(
    parameter int NUM_CS = 6,
    parameter int CS_W   = 3
) (
    input  logic [CS_W-1:0]          sel,
    input  logic [NUM_CS*WAIT_W-1:0] rd_wait_v,
    input  logic [NUM_CS*WAIT_W-1:0] wr_wait_v,
    input  logic [NUM_CS*WAIT_W-1:0] wr_hold_v,
    input  logic [NUM_CS*WAIT_W-1:0] recov_v,
    input  logic [NUM_CS*LAT_W-1:0]  rd_lat_v,
    input  logic [NUM_CS*LAT_W-1:0]  wr_lat_v,
    output timing_t                  tsel
);
    localparam int SLOTS = 1 << CS_W;

    timing_t table_q [SLOTS];

    generate
        for (genvar i = 0; i < SLOTS; i++) begin : g_slot
            if (i < NUM_CS) begin : g_used
                assign table_q[i] = '{
                    rd_wait: rd_wait_v[i*WAIT_W +: WAIT_W],
                    wr_wait: wr_wait_v[i*WAIT_W +: WAIT_W],
                    wr_hold: wr_hold_v[i*WAIT_W +: WAIT_W],
                    recov:   recov_v[i*WAIT_W +: WAIT_W],
                    rd_lat:  rd_lat_v[i*LAT_W +: LAT_W],
                    wr_lat:  wr_lat_v[i*LAT_W +: LAT_W]
                };
            end else begin : g_pad
                assign table_q[i] = '0;
            end
        end
    endgenerate

    assign tsel = table_q[sel];
endmodule

// File: rtl/async_mem_hist.sv
module async_mem_hist
    import async_mem_pkg::*;
#(
    parameter int CS_W   = 3,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [CS_W-1:0]   cs,
    input  logic [PAGE_W-1:0] page,
    input  logic              is_write,
    input  logic [WAIT_W-1:0] recov_in,
    output logic              need_recov,
    output logic              new_page,
    output logic [WAIT_W-1:0] last_recov
);
    logic              valid_q;
    logic              last_rd_q;
    logic [CS_W-1:0]   last_cs_q;
    logic [PAGE_W-1:0] last_pg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q    <= 1'b0;
            last_rd_q  <= 1'b0;
            last_cs_q  <= '0;
            last_pg_q  <= '0;
            last_recov <= '0;
        end else if (upd) begin
            valid_q    <= 1'b1;
            last_rd_q  <= ~is_write;
            last_cs_q  <= cs;
            last_pg_q  <= page;
            last_recov <= recov_in;
        end
    end

    always_comb begin
        need_recov = valid_q && last_rd_q && ((cs != last_cs_q) || is_write);
        new_page   = !valid_q || (cs != last_cs_q) || (page != last_pg_q);
    end
endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
    import async_mem_pkg::*;
#(
    parameter int NUM_CS = 6,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16,
    parameter int OFF_W  = 4,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [CS_W-1:0]           req_cs,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      req_write,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      rsp_done,
    output logic [DATA_W-1:0]         rsp_rdata,
    input  logic [NUM_CS*WAIT_W-1:0]  cfg_rd_wait,
    input  logic [NUM_CS*WAIT_W-1:0]  cfg_wr_wait,
    input  logic [NUM_CS*WAIT_W-1:0]  cfg_wr_hold,
    input  logic [NUM_CS*WAIT_W-1:0]  cfg_recov,
    input  logic [NUM_CS*LAT_W-1:0]   cfg_rd_lat,
    input  logic [NUM_CS*LAT_W-1:0]   cfg_wr_lat,
    output logic [NUM_CS-1:0]         ext_cs_n,
    output logic [ADDR_W-1:0]         ext_addr,
    output logic                      ext_oe_n,
    output logic                      ext_we_n,
    output logic [DATA_W-1:0]         ext_dq_out,
    output logic                      ext_dq_oe,
    input  logic [DATA_W-1:0]         ext_dq_in
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    state_t            state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;

    logic [CS_W-1:0]   cur_cs;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_write;
    logic [DATA_W-1:0] cur_wdata;
    logic              cur_newpg;

    logic              idle;
    logic              accept;
    logic [CS_W-1:0]   sel_cs;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_wr;
    logic [DATA_W-1:0] sel_wdata;
    logic [NUM_CS-1:0] sel_onehot;

    timing_t           tim;
    logic              need_recov;
    logic              new_page;
    logic [WAIT_W-1:0] last_recov;
    logic [WAIT_W-1:0] rec_eff;
    logic [LAT_W-1:0]  lat_v;
    logic [WAIT_W-1:0] wait_v;
    logic              bus_sel;

    assign idle      = (state == ST_IDLE);
    assign accept    = idle && req_valid;
    assign req_ready = idle;
    assign sel_cs    = idle ? req_cs    : cur_cs;
    assign sel_addr  = idle ? req_addr  : cur_addr;
    assign sel_wr    = idle ? req_write : cur_write;
    assign sel_wdata = idle ? req_wdata : cur_wdata;

    async_mem_cfgmux #(.NUM_CS(NUM_CS), .CS_W(CS_W)) i_cfgmux (
        .sel       (sel_cs),
        .rd_wait_v (cfg_rd_wait),
        .wr_wait_v (cfg_wr_wait),
        .wr_hold_v (cfg_wr_hold),
        .recov_v   (cfg_recov),
        .rd_lat_v  (cfg_rd_lat),
        .wr_lat_v  (cfg_wr_lat),
        .tsel      (tim)
    );

    async_mem_hist #(.CS_W(CS_W), .PAGE_W(PAGE_W)) i_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (accept),
        .cs         (req_cs),
        .page       (req_addr[ADDR_W-1:OFF_W]),
        .is_write   (req_write),
        .recov_in   (tim.recov),
        .need_recov (need_recov),
        .new_page   (new_page),
        .last_recov (last_recov)
    );

    always_comb begin
        for (int i = 0; i < NUM_CS; i++) begin
            sel_onehot[i] = (sel_cs == CS_W'(i));
        end
    end

    // Request latch: fields of the accepted access.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_cs    <= '0;
            cur_addr  <= '0;
            cur_write <= 1'b0;
            cur_wdata <= '0;
            cur_newpg <= 1'b0;
        end else if (accept) begin
            cur_cs    <= req_cs;
            cur_addr  <= req_addr;
            cur_write <= req_write;
            cur_wdata <= req_wdata;
            cur_newpg <= new_page;
        end
    end

    // Next-state logic.
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        rec_eff = (last_recov == '0) ? WAIT_W'(1) : last_recov;
        lat_v   = sel_wr ? tim.wr_lat  : tim.rd_lat;
        wait_v  = sel_wr ? tim.wr_wait : tim.rd_wait;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (need_recov) begin
                        state_n = ST_RECOV;
                        cnt_n   = CNT_W'(rec_eff) - CNT_W'(1);
                    end else if (new_page && (lat_v != '0)) begin
                        state_n = ST_LAT;
                        cnt_n   = CNT_W'(lat_v) - CNT_W'(1);
                    end else begin
                        state_n = sel_wr ? ST_WRITE : ST_READ;
                        cnt_n   = CNT_W'(wait_v);
                    end
                end
            end
            ST_RECOV: begin
                if (cnt == '0) begin
                    if (cur_newpg && (lat_v != '0)) begin
                        state_n = ST_LAT;
                        cnt_n   = CNT_W'(lat_v) - CNT_W'(1);
                    end else begin
                        state_n = sel_wr ? ST_WRITE : ST_READ;
                        cnt_n   = CNT_W'(wait_v);
                    end
                end else begin
                    cnt_n = cnt - CNT_W'(1);
                end
            end
            ST_LAT: begin
                if (cnt == '0) begin
                    state_n = sel_wr ? ST_WRITE : ST_READ;
                    cnt_n   = CNT_W'(wait_v);
                end else begin
                    cnt_n = cnt - CNT_W'(1);
                end
            end
            ST_READ: begin
                if (cnt == '0) state_n = ST_IDLE;
                else           cnt_n   = cnt - CNT_W'(1);
            end
            ST_WRITE: begin
                if (cnt == '0) begin
                    state_n = ST_HOLD;
                    cnt_n   = CNT_W'(tim.wr_hold);
                end else begin
                    cnt_n = cnt - CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (cnt == '0) state_n = ST_IDLE;
                else           cnt_n   = cnt - CNT_W'(1);
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    assign bus_sel = (state_n == ST_LAT) || (state_n == ST_READ) ||
                     (state_n == ST_WRITE) || (state_n == ST_HOLD);

    // Output register: bus pins decoded from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_cs_n   <= '1;
            ext_addr   <= '0;
            ext_oe_n   <= 1'b1;
            ext_we_n   <= 1'b1;
            ext_dq_out <= '0;
            ext_dq_oe  <= 1'b0;
        end else begin
            ext_cs_n   <= bus_sel ? ~sel_onehot : '1;
            ext_addr   <= sel_addr;
            ext_oe_n   <= (state_n != ST_READ);
            ext_we_n   <= (state_n != ST_WRITE);
            ext_dq_out <= sel_wdata;
            ext_dq_oe  <= (state_n == ST_WRITE) || (state_n == ST_HOLD);
        end
    end

    // Completion and read capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= (cnt == '0) && ((state == ST_READ) || (state == ST_HOLD));
            if ((state == ST_READ) && (cnt == '0)) rsp_rdata <= ext_dq_in;
        end
    end
endmodule

// File: rtl/async_mem_chk.sv
module async_mem_chk #(
    parameter int NUM_CS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [NUM_CS-1:0] ext_cs_n,
    input logic              ext_oe_n,
    input logic              ext_we_n,
    input logic              ext_dq_oe
);
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_oe_n && !ext_we_n));

    assert_cs_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));

    assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_oe_n |-> !ext_dq_oe);

    assert_oe_has_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_oe_n |-> ($countones(~ext_cs_n) == 1));

    assert_we_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_we_n |-> (ext_dq_oe && ($countones(~ext_cs_n) == 1)));

    assert_hold_after_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_we_n) |-> (ext_dq_oe && !(&ext_cs_n)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ext_oe_n && ext_we_n && !ext_dq_oe && (&ext_cs_n)));
endmodule

bind async_mem_ctrl async_mem_chk #(.NUM_CS(NUM_CS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .ext_cs_n  (ext_cs_n),
    .ext_oe_n  (ext_oe_n),
    .ext_we_n  (ext_we_n),
    .ext_dq_oe (ext_dq_oe)
);

// File: tb/test_async_mem_ctrl.sv
module test_async_mem_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCS = 6;
    localparam int AW  = 9;
    localparam int DW  = 16;
    localparam int MEMN = NCS * (1 << AW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_cs = '0;
    logic [AW-1:0] req_addr = '0;
    logic req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [NCS*4-1:0] cfg_rd_wait, cfg_wr_wait, cfg_wr_hold, cfg_recov;
    logic [NCS*8-1:0] cfg_rd_lat, cfg_wr_lat;
    logic [NCS-1:0] ext_cs_n;
    logic [AW-1:0] ext_addr;
    logic ext_oe_n, ext_we_n, ext_dq_oe;
    logic [DW-1:0] ext_dq_out, ext_dq_in;

    int b_rdw [NCS] = '{2, 0, 5, 1, 3, 15};
    int b_wrw [NCS] = '{1, 3, 0, 1, 2, 15};
    int b_hld [NCS] = '{0, 2, 4, 1, 0, 15};
    int b_rec [NCS] = '{0, 3, 1, 2, 5, 15};
    int b_rdl [NCS] = '{3, 0, 1, 0, 2, 255};
    int b_wrl [NCS] = '{2, 0, 4, 6, 0, 12};

    logic [DW-1:0] bus_mem [MEMN];
    logic [DW-1:0] shadow  [MEMN];

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;
    bit  h_valid = 1'b0;
    bit  h_last_rd = 1'b0;
    int  h_last_cs = 0;
    int  h_last_pg = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCS; i++) begin
            cfg_rd_wait[i*4 +: 4] = 4'(b_rdw[i]);
            cfg_wr_wait[i*4 +: 4] = 4'(b_wrw[i]);
            cfg_wr_hold[i*4 +: 4] = 4'(b_hld[i]);
            cfg_recov[i*4 +: 4]   = 4'(b_rec[i]);
            cfg_rd_lat[i*8 +: 8]  = 8'(b_rdl[i]);
            cfg_wr_lat[i*8 +: 8]  = 8'(b_wrl[i]);
        end
    end

    int bus_idx;
    always_comb begin
        bus_idx = 0;
        for (int i = 0; i < NCS; i++) begin
            if (!ext_cs_n[i]) bus_idx = i * (1 << AW) + int'(ext_addr);
        end
        ext_dq_in = (!ext_oe_n) ? bus_mem[bus_idx] : 16'h0000;
    end

    always @(posedge clk) begin
        if (!ext_we_n && ext_dq_oe) bus_mem[bus_idx] <= ext_dq_out;
    end

    async_mem_ctrl i_async_mem_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait),
        .cfg_wr_hold(cfg_wr_hold), .cfg_recov(cfg_recov),
        .cfg_rd_lat(cfg_rd_lat), .cfg_wr_lat(cfg_wr_lat),
        .ext_cs_n(ext_cs_n), .ext_addr(ext_addr), .ext_oe_n(ext_oe_n),
        .ext_we_n(ext_we_n), .ext_dq_out(ext_dq_out), .ext_dq_oe(ext_dq_oe),
        .ext_dq_in(ext_dq_in)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < MEMN; i++) begin
            bus_mem[i] = 16'((i * 40503) ^ 23130);
            shadow[i]  = bus_mem[i];
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", int'(ext_cs_n), 63);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cs_n", int'(ext_cs_n), 63);
        chk("R1 oe_n", int'(ext_oe_n), 1);
        chk("R1 we_n", int'(ext_we_n), 1);
        chk("R1 dq_oe", int'(ext_dq_oe), 0);
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 done", int'(rsp_done), 0);
        h_valid = 1'b0;
    endtask

    // One access with all timing checks computed from the requirements.
    task automatic run_access(input int cs, input int addr, input bit wr,
                              input logic [DW-1:0] wd);
        int rec, lat, w, h, total, newpg, idx;
        int k, gap, csl, oel, wel, dqo, bad, busy_rdy;
        bit seen;
        logic [DW-1:0] exp_rd;
        idx = cs * (1 << AW) + addr;
        rec = 0;
        if (h_valid && h_last_rd && (cs != h_last_cs || wr))
            rec = (b_rec[h_last_cs] == 0) ? 1 : b_rec[h_last_cs];
        newpg = (!h_valid || cs != h_last_cs || (addr >> 4) != h_last_pg) ? 1 : 0;
        lat = newpg ? (wr ? b_wrl[cs] : b_rdl[cs]) : 0;
        w = (wr ? b_wrw[cs] : b_rdw[cs]) + 1;
        h = wr ? b_hld[cs] + 1 : 0;
        total = rec + lat + w + h;
        exp_rd = shadow[idx];
        if (wr) shadow[idx] = wd;
        h_valid = 1'b1; h_last_rd = !wr; h_last_cs = cs; h_last_pg = addr >> 4;

        @(negedge clk);
        chk("R8 ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_cs = 3'(cs); req_addr = 9'(addr);
        req_write = wr; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        k = 1; gap = 0; csl = 0; oel = 0; wel = 0; dqo = 0; bad = 0; busy_rdy = 0;
        seen = 1'b0;
        while (!rsp_done && k < 2000) begin
            if (req_ready) busy_rdy++;
            if (&ext_cs_n) begin
                if (!seen) gap++;
            end else begin
                seen = 1'b1;
                csl++;
                if (ext_cs_n != ~(6'(1) << cs)) bad++;
                if (int'(ext_addr) != addr) bad++;
            end
            if (!ext_oe_n) oel++;
            if (!ext_we_n) begin
                wel++;
                if (ext_dq_out != wd) bad++;
            end
            if (ext_dq_oe) dqo++;
            @(negedge clk);
            k++;
        end
        chk("R8 access time", k - 1, total);
        chk("R8 ready low while busy", busy_rdy, 0);
        chk(rec > 0 ? "R5 recovery gap" : "R6 no recovery gap", gap, rec);
        chk("R7 cs low window incl latency", csl, lat + w + h);
        chk("R2 oe low cycles", oel, wr ? 0 : w);
        chk("R3 we low cycles", wel, wr ? w : 0);
        chk("R4 data driven cycles", dqo, wr ? w + h : 0);
        chk("R9 select/address/data lanes", bad, 0);
        if (!wr) chk("R2 read data", int'(rsp_rdata), int'(exp_rd));
        @(negedge clk);
        chk("R8 done single pulse", int'(rsp_done), 0);
    endtask

    task automatic t_first_read();        run_access(0, 9'h010, 1'b0, 16'h0); endtask
    task automatic t_same_page_read();    run_access(0, 9'h01F, 1'b0, 16'h0); endtask
    task automatic t_read_write_same();   run_access(0, 9'h012, 1'b1, 16'hA55A); endtask
    task automatic t_write_then_other();  run_access(1, 9'h012, 1'b1, 16'h1234); endtask
    task automatic t_readback();          run_access(1, 9'h012, 1'b0, 16'h0); endtask
    task automatic t_read_to_other();     run_access(2, 9'h100, 1'b0, 16'h0); endtask
    task automatic t_page_change();       run_access(2, 9'h110, 1'b0, 16'h0); endtask
    task automatic t_max_write();         run_access(5, 9'h1FF, 1'b1, 16'hBEEF); endtask
    task automatic t_max_readback();      run_access(5, 9'h1FF, 1'b0, 16'h0); endtask
    task automatic t_max_recovery();      run_access(4, 9'h000, 1'b0, 16'h0); endtask
    task automatic t_cs3_write_read();
        run_access(3, 9'h0A5, 1'b1, 16'h0F0F);
        run_access(3, 9'h0A5, 1'b0, 16'h0);
    endtask

    task automatic t_reset_clears_history();
        t_reset();
        run_access(0, 9'h010, 1'b0, 16'h0);
    endtask

    initial begin
        t_reset();
        t_first_read();
        t_same_page_read();
        t_read_write_same();
        t_write_then_other();
        t_readback();
        t_read_to_other();
        t_page_change();
        t_max_write();
        t_max_readback();
        t_max_recovery();
        t_cs3_write_read();
        t_reset_clears_history();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule